// File: doc/BRIEF.md
# Three-Channel Interval Timer

The block holds three independent 16-bit up-counters that share one input clock and a simple register bus with a write strobe and a read strobe. Each channel can count freely, wrapping from 0xFFFF to zero, or run as an interval timer that counts from zero up to a programmed limit and then starts again at zero. An optional power-of-two prescaler slows a channel's count rate. Every channel drives its own interrupt line.

Software configures a channel by writing its clock-control, counter-control, interval and interrupt-enable registers. It reads the live count at any time. It acknowledges an interrupt by reading the status register, and that read clears the flags. All registers of one kind sit in a shared bank, and channel n uses the bank offset plus 4n.

Top module: `tri_interval_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low. The one exception is counter control, which reads 0x01 so that the channel starts disabled.
- R2: An enabled channel adds exactly one to its count per count tick. In free-running mode (counter control bit 1 = 0) it wraps from 0xFFFF to 0 and sets status bit 4.
- R3: While counter control bit 0 (disable) is 1, the count holds its value. Once the bit is cleared, counting resumes from the held value.
- R4: Writing counter control with bit 4 set forces the count and the prescale divider to zero at that edge. Bit 4 always reads back as 0. Bits 5, 3, 2 and 1 read back as written.
- R5: Clock control bit 0 enables the prescaler, and bits [4:1] hold an exponent N. With the prescaler on, the count advances once every 2^(N+1) clocks. The first advance comes a full period after the channel is reset or enabled. With the prescaler off, the count advances on every clock.
- R6: In interval mode (counter control bit 1 = 1), a tick taken while the count equals the interval register returns the count to 0 and sets status bit 0.
- R7: A read of the status register returns the pending flags and clears them. A flag raised on the same edge as the clearing read survives.
- R8: `irq[n]` is high exactly when a status bit of channel n is set and its interrupt-enable bit is set. Enable bit 0 gates the interval flag and enable bit 4 gates the wrap flag.
- R9: The register banks are clock control 0x00, counter control 0x0C, count 0x18, interval 0x24, status 0x54 and interrupt enable 0x60, with channel n at +4n. The count register ignores writes.
- R10: Activity on one channel never alters the count of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| rd_en | input | 1 | Read strobe; clears status at the edge when `addr` selects a status register |
| addr | input | 8 | Byte address of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 3 | Per-channel interrupt, one bit per channel |

## Verification
The properties assume that the only way to zero a count outside a wrap or an interval match is a counter-control write with bit 4 set. They also assume that bus strobes last a single cycle each, with stable address and data. The stimulus issues every access as a one-cycle strobe, driven on the falling edge. It always disables a channel and clears its status before reprogramming it. Intervals, exponents and wait lengths are drawn at random within ranges small enough for the bench to predict every count and flag exactly. Directed runs cover the full wrap, the same-edge flag survival and the first prescaled tick.

// File: rtl/tri_interval_timer.sv
module tri_interval_timer #(
  parameter int CH = 3,
  parameter int CW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [CH-1:0] irq
);
  localparam int OFF_CLK = 'h00;
  localparam int OFF_CTL = 'h0C;
  localparam int OFF_CNT = 'h18;
  localparam int OFF_IVL = 'h24;
  localparam int OFF_STS = 'h54;
  localparam int OFF_IEN = 'h60;
  localparam int STRIDE  = 4;
  localparam logic [CW:0] ONE = 1;

  logic [CH-1:0][4:0]    clk_cfg;
  logic [CH-1:0][5:0]    ctl;
  logic [CH-1:0][CW-1:0] cnt;
  logic [CH-1:0][CW-1:0] ivl;
  logic [CH-1:0][4:0]    sts;
  logic [CH-1:0][4:0]    ien;
  logic [CH-1:0][CW:0]   div;
  logic [CH-1:0]         halted, ctl_wr, clr_req;

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic hit_clk, hit_ivl, hit_sts, hit_ien;
    logic tick, match, wrap;
    logic [4:0]  sh;
    logic [CW:0] lim;

    assign hit_clk = addr == AW'(OFF_CLK + STRIDE*i);
    assign hit_ivl = addr == AW'(OFF_IVL + STRIDE*i);
    assign hit_sts = addr == AW'(OFF_STS + STRIDE*i);
    assign hit_ien = addr == AW'(OFF_IEN + STRIDE*i);
    assign ctl_wr[i]  = wr_en && addr == AW'(OFF_CTL + STRIDE*i);
    assign clr_req[i] = ctl_wr[i] & wdata[4];
    assign halted[i]  = ctl[i][0];

    assign sh    = {1'b0, clk_cfg[i][4:1]} + 5'd1;
    assign lim   = (ONE << sh) - ONE;
    assign tick  = ~halted[i] & (~clk_cfg[i][0] | (div[i] == lim));
    assign match = tick & ctl[i][1] & (cnt[i] == ivl[i]);
    assign wrap  = tick & ~match & (cnt[i] == '1);
    assign irq[i] = |(sts[i] & ien[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        clk_cfg[i] <= '0;
        ctl[i]     <= 6'h01;
        cnt[i]     <= '0;
        ivl[i]     <= '0;
        sts[i]     <= '0;
        ien[i]     <= '0;
        div[i]     <= '0;
      end else begin
        if (wr_en && hit_clk) clk_cfg[i] <= wdata[4:0];
        if (ctl_wr[i])        ctl[i] <= {wdata[5], 1'b0, wdata[3:0]};
        if (wr_en && hit_ivl) ivl[i] <= wdata;
        if (wr_en && hit_ien) ien[i] <= {wdata[4], 3'b000, wdata[0]};
        sts[i] <= ((rd_en && hit_sts) ? 5'b0 : sts[i]) | {wrap, 3'b000, match};
        if (clr_req[i] || halted[i] || !clk_cfg[i][0] || tick) div[i] <= '0;
        else div[i] <= div[i] + ONE;
        if (clr_req[i])  cnt[i] <= '0;
        else if (tick)   cnt[i] <= (match || wrap) ? '0 : cnt[i] + 1'b1;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < CH; i++) begin
      if (addr == AW'(OFF_CLK + STRIDE*i)) rdata = CW'(clk_cfg[i]);
      if (addr == AW'(OFF_CTL + STRIDE*i)) rdata = CW'(ctl[i]);
      if (addr == AW'(OFF_CNT + STRIDE*i)) rdata = cnt[i];
      if (addr == AW'(OFF_IVL + STRIDE*i)) rdata = ivl[i];
      if (addr == AW'(OFF_STS + STRIDE*i)) rdata = CW'(sts[i]);
      if (addr == AW'(OFF_IEN + STRIDE*i)) rdata = CW'(ien[i]);
    end
  end
endmodule

// File: rtl/tri_interval_timer_chk.sv
module tri_interval_timer_chk #(
  parameter int CH = 3,
  parameter int CW = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [CH-1:0]         irq,
  input logic [CH-1:0]         halted,
  input logic [CH-1:0]         ctl_wr,
  input logic [CH-1:0]         clr_req,
  input logic [CH-1:0][CW-1:0] cnt,
  input logic [CH-1:0][4:0]    ien
);
  for (genvar i = 0; i < CH; i++) begin : g_chk
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cnt[i]) |-> (cnt[i] == $past(cnt[i]) + 1'b1 || cnt[i] == '0));

    assert_hold_when_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (halted[i] && !ctl_wr[i]) |=> $stable(cnt[i]));

    assert_reset_zeroes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req[i] |=> cnt[i] == '0);

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |-> ien[i] != '0);
  end
endmodule

bind tri_interval_timer tri_interval_timer_chk #(.CH(CH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .halted(halted), .ctl_wr(ctl_wr),
  .clr_req(clr_req), .cnt(cnt), .ien(ien)
);

// File: tb/tri_interval_timer_bench.sv
module tri_interval_timer_bench;
  localparam int PERIOD = 10;
  localparam int CLK = 'h00, CTL = 'h0C, CNT = 'h18, IVL = 'h24, STS = 'h54, IEN = 'h60;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic [2:0] irq;
  int checks = 0, fails = 0;
  bit done = 0;

  tri_interval_timer u_tri_interval_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int exp_count(int edges, int div, int ivl);
    return (edges / div) % (ivl + 1);
  endfunction

  function automatic int exp_match(int edges, int div, int ivl);
    return ((edges / div) >= ivl + 1) ? 1 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    addr = 8'(a); wdata = 16'(d); wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int a, output int d, output int iv);
    addr = 8'(a); rd_en = 1;
    #1;
    d = int'(rdata); iv = int'(irq);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 190000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int d, iv, held;
    void'($urandom(32'h5eed_7103));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    for (int c = 0; c < 3; c++) begin
      rd(CLK + 4*c, d, iv); chk("R1 clk", d, 0);
      rd(CTL + 4*c, d, iv); chk("R1 ctl", d, 1);
      rd(CNT + 4*c, d, iv); chk("R1 cnt", d, 0);
      rd(IVL + 4*c, d, iv); chk("R1 ivl", d, 0);
      rd(STS + 4*c, d, iv); chk("R1 sts", d, 0);
      rd(IEN + 4*c, d, iv); chk("R1 ien", d, 0);
    end

    // R3 disable/resume, R4 reset bit, R9 count read-only
    wr(IVL, 1000); wr(CLK, 0); wr(CTL, 'h12);
    repeat (5) @(negedge clk);
    wr(CTL, 'h03);
    rd(CNT, d, iv); chk("R3 count at disable", d, 6);
    repeat (10) @(negedge clk);
    rd(CNT, d, iv); chk("R3 held", d, 6);
    wr(CTL, 'h02);
    repeat (3) @(negedge clk);
    rd(CNT, d, iv); chk("R3 resumed", d, 9);
    wr(CTL, 'h32);
    rd(CTL, d, iv); chk("R4 reset bit readback", d, 'h22);
    wr(CNT, 'h1234);
    rd(CNT, d, iv); chk("R9 count ignores write", d, 2);
    wr(CTL, 'h01);

    // R7 same-edge survival, R6 interval match, R8 irq
    wr(IVL + 4, 3); wr(CLK + 4, 0); wr(IEN + 4, 1); wr(CTL + 4, 'h12);
    repeat (7) @(negedge clk);
    rd(STS + 4, d, iv); chk("R6 match flag", d, 1); chk("R8 irq set", (iv >> 1) & 1, 1);
    rd(STS + 4, d, iv); chk("R7 survived same-edge event", d, 1);
    rd(STS + 4, d, iv); chk("R7 cleared by read", d, 0); chk("R8 irq low", (iv >> 1) & 1, 0);
    wr(CTL + 4, 'h01);

    // R5 first prescaled tick a full period after reset write
    wr(CLK, 'h05); wr(IVL, 100); wr(CTL, 'h12);
    repeat (7) @(negedge clk);
    rd(CNT, d, iv); chk("R5 before first tick", d, 0);
    rd(CNT, d, iv); chk("R5 first tick", d, 1);
    repeat (6) @(negedge clk);
    rd(CNT, d, iv); chk("R5 steady", d, 1);
    rd(CNT, d, iv); chk("R5 second tick", d, 2);
    wr(CTL, 'h01);
    rd(CNT, held, iv);

    // R2 full wrap on channel 2, R10 independence
    wr(CLK + 8, 0); wr(IEN + 8, 'h10); wr(CTL + 8, 'h10);
    repeat (65535) @(negedge clk);
    rd(CNT + 8, d, iv); chk("R2 top count", d, 'hFFFF);
    rd(STS + 8, d, iv); chk("R2 wrap flag", d, 'h10); chk("R8 wrap irq", (iv >> 2) & 1, 1);
    #1; chk("R7 irq after clear", int'(irq[2]), 0);
    rd(CNT + 8, d, iv); chk("R2 restarted at zero", d, 1);
    wr(CTL + 8, 'h01);
    rd(CNT, d, iv); chk("R10 channel 0 untouched", d, held);

    // Random interval runs: R5 R6 R8 R9
    for (int it = 0; it < 40; it++) begin
      int c, n, pe, dv, iv_lim, k, ie, base;
      c = int'($urandom % 3); base = 4 * c;
      n = int'($urandom % 4); pe = int'($urandom % 2);
      dv = pe ? (1 << (n + 1)) : 1;
      iv_lim = 1 + int'($urandom % 40); k = int'($urandom % 300);
      ie = int'($urandom % 2);
      wr(CTL + base, 'h01);
      rd(STS + base, d, iv);
      wr(IVL + base, iv_lim); wr(CLK + base, (n << 1) | pe);
      wr(IEN + base, ie); wr(CTL + base, 'h12);
      repeat (k) @(negedge clk);
      rd(CNT + base, d, iv); chk("R5 R6 random count", d, exp_count(k, dv, iv_lim));
      rd(STS + base, d, iv); chk("R6 R9 random status", d, exp_match(k + 1, dv, iv_lim));
      chk("R8 random irq", (iv >> c) & 1, exp_match(k + 1, dv, iv_lim) & ie);
    end

    finish_run();
  end
endmodule